// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers eight interrupt request lines, latches a rising edge on each one, and picks a winner by fixed priority, with line 0 highest. When the winner outranks every line already being serviced, it raises a single interrupt output. An acknowledge pulse moves the winner into service and presents an 8-bit vector: a programmed base plus the line number. Software ends the service with a non-specific end-of-interrupt command.

The block is reached through two byte-wide addresses selected by one address bit. Address 0 is the command port and address 1 is the data port. A command write with bit 4 set starts a new setup sequence. The data port then takes the vector base, an optional cascade word and an optional mode word. After that, every data-port write loads the mask register. Until the sequence is complete, the controller accepts no requests.

Top module: `intc8`

## Requirements
- R1: After reset the controller is uninitialized, `irq_out` is 0, and the mask reads 0xFF.
- R2: A command-port write with bit 4 set restarts setup. It sets the mask to 0xFF and clears all pending and in-service bits. Its bit 1 set means single mode, and its bit 0 set means a mode word will follow.
- R3: After the setup command, the first data write is the vector base. A cascade word follows only if bit 1 was clear, and a mode word follows only if bit 0 was set. Once setup is complete, each data write loads the mask, where a 1 bit masks its line.
- R4: A read (`rd`=1) returns the mask at address 1 and the pending-request bits at address 0. With `rd`=0, `dout` is 0.
- R5: A rising edge on a line sets its pending bit, but only once setup is complete. Edges that arrive before then are dropped, and a line held high does not request again.
- R6: A masked line raises no interrupt, but its edge stays pending. The interrupt is raised once the line is unmasked.
- R7: `irq_out` is 1 exactly when an unmasked pending line exists whose index is lower than every in-service line. Line 0 has the highest priority.
- R8: An `ack` pulse while `irq_out` is 1 moves the winning line from pending to in-service. On the next cycle, `vector` shows base plus the line number.
- R9: A command write of 0x20 clears the in-service bit with the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| irq_in | input | NLINES | Request lines |
| irq_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge pulse |
| vector | output | 8 | Vector of the last acknowledged line |

## Verification
The bench builds the controller with the default of eight lines. With this width every priority position can be reached, including nesting of a high line above a lower one already in service, and the top line with the highest index. Setup is run twice. The first run uses the full four-word order. The second uses a single-mode run with no mode word, which shows that the skip paths steer the next data write to the mask.

// File: rtl/intc8.sv
module intc8 #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  input  logic [NLINES-1:0] irq_in,
  output logic              irq_out,
  input  logic              ack,
  output logic [7:0]        vector
);
  localparam int LW = $clog2(NLINES);

  typedef enum logic [2:0] {S_OFF, S_BASE, S_CASC, S_MODE, S_RUN} st_t;
  st_t state;

  logic [NLINES-1:0] mask, irr, isr, prev;
  logic [7:0]        base;
  logic              single, want_mode;
  logic [NLINES-1:0] pend;
  logic [LW-1:0]     p_idx, s_idx;
  logic              p_any, s_any;

  wire cmd_wr  = wr && !port_sel;
  wire data_wr = wr && port_sel;
  wire setup   = cmd_wr && din[4];
  wire eoi     = cmd_wr && (din == 8'h20) && (state == S_RUN);
  wire take    = ack && irq_out;

  assign pend = irr & ~mask;

  always_comb begin
    p_idx = '0; p_any = 1'b0;
    s_idx = '0; s_any = 1'b0;
    for (int i = NLINES-1; i >= 0; i--) begin
      if (pend[i]) begin p_idx = LW'(i); p_any = 1'b1; end
      if (isr[i])  begin s_idx = LW'(i); s_any = 1'b1; end
    end
  end

  assign irq_out = (state == S_RUN) && p_any && (!s_any || p_idx < s_idx);
  assign dout    = !rd ? 8'h00 : port_sel ? 8'(mask) : 8'(irr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      mask      <= '1;
      irr       <= '0;
      isr       <= '0;
      prev      <= '0;
      base      <= '0;
      single    <= 1'b0;
      want_mode <= 1'b0;
      vector    <= '0;
    end else begin
      prev <= irq_in;
      if (state == S_RUN) irr <= irr | (irq_in & ~prev);
      if (take) begin
        irr[p_idx] <= 1'b0;
        isr[p_idx] <= 1'b1;
        vector     <= base + 8'(p_idx);
      end
      if (eoi && s_any) isr[s_idx] <= 1'b0;
      if (data_wr) begin
        case (state)
          S_BASE: begin
            base  <= din;
            state <= !single ? S_CASC : want_mode ? S_MODE : S_RUN;
          end
          S_CASC:  state <= want_mode ? S_MODE : S_RUN;
          S_MODE:  state <= S_RUN;
          S_RUN:   mask  <= din[NLINES-1:0];
          default: ;
        endcase
      end
      if (setup) begin
        state     <= S_BASE;
        single    <= din[1];
        want_mode <= din[0];
        mask      <= '1;
        irr       <= '0;
        isr       <= '0;
      end
    end
  end

  // R2
  setup_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> (state == S_BASE) && (&mask) && (isr == '0) && (irr == '0));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && state == S_RUN && !setup) |=> mask == $past(din[NLINES-1:0]));

  // R8
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !setup && !eoi) |=> $countones(isr) == $past($countones(isr)) + 1);

  // R9
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && !ack) |=> $countones(isr) == $past($countones(isr)) - 1);

  // R7
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN) |-> !irq_out);
endmodule

// File: tb/test_intc8.sv
module test_intc8;
  logic clk = 0, rst_n = 0;
  logic port_sel = 0, wr = 0, rd = 0, ack = 0;
  logic [7:0] din = 0, irq_in = 0;
  logic [7:0] dout, vector;
  logic irq_out;
  int checks = 0, errors = 0;
  logic [7:0] expq[$];
  bit done = 0;

  always #10 clk = ~clk;

  intc8 i_intc8 (.clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr(wr), .rd(rd),
    .din(din), .dout(dout), .irq_in(irq_in), .irq_out(irq_out), .ack(ack), .vector(vector));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", req, act, exp); end
  endtask

  task automatic wr_port(input logic sel, input logic [7:0] v);
    @(negedge clk); port_sel = sel; din = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_port(input logic sel, output logic [7:0] v);
    @(negedge clk); port_sel = sel; rd = 1; #1 v = dout; rd = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v; @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] exp);
    @(negedge clk); expq.push_back(exp); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk); check(irq_out === exp, req, irq_out, exp);
  endtask

  task automatic chk_rd(input logic sel, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd_port(sel, v); check(v === exp, req, v, exp);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial forever begin
    @(posedge clk);
    if (ack) begin
      @(negedge clk);
      if (expq.size() == 0) check(0, "R8 unexpected ack", vector, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(vector === e, "R8 vector", vector, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    chk_irq(0, "R1 irq after reset");
    chk_rd(1, 8'hFF, "R1 mask after reset");
    set_irq(8'h08);
    chk_irq(0, "R5 request before setup");
    set_irq(8'h00);
    wr_port(0, 8'h11);
    chk_rd(1, 8'hFF, "R2 mask after setup cmd");
    wr_port(1, 8'h20); wr_port(1, 8'h04); wr_port(1, 8'h01);
    chk_rd(1, 8'hFF, "R3 mode word not taken as mask");
    wr_port(1, 8'h00);
    chk_rd(1, 8'h00, "R3 mask load");
    chk_irq(0, "R5 early edge dropped");
    @(negedge clk); check(dout === 8'h00, "R4 no read gives zero", dout, 0);
    // nesting
    set_irq(8'h20); chk_irq(1, "R7 line5 raises");
    do_ack(8'h25);
    set_irq(8'h24); chk_irq(1, "R7 line2 preempts");
    do_ack(8'h22);
    set_irq(8'h64); chk_irq(0, "R7 line6 below service");
    wr_port(0, 8'h20); chk_irq(0, "R9 line5 still in service");
    wr_port(0, 8'h20); chk_irq(1, "R9 line6 now allowed");
    do_ack(8'h26);
    wr_port(0, 8'h20);
    chk_irq(0, "R5 held level no retrigger");
    set_irq(8'h00);
    // simultaneous
    set_irq(8'h12);
    do_ack(8'h21);
    chk_irq(0, "R7 line4 below line1");
    wr_port(0, 8'h20); chk_irq(1, "R9 line4 after eoi");
    do_ack(8'h24);
    wr_port(0, 8'h20); set_irq(8'h00);
    // masking
    wr_port(1, 8'h08);
    chk_rd(1, 8'h08, "R4 mask readback");
    set_irq(8'h08); chk_irq(0, "R6 masked line");
    chk_rd(0, 8'h08, "R6 pending kept");
    wr_port(1, 8'h00); chk_irq(1, "R6 unmask raises");
    do_ack(8'h23);
    chk_rd(0, 8'h00, "R8 pending cleared");
    wr_port(0, 8'h20); set_irq(8'h00);
    // single mode, no mode word
    wr_port(0, 8'h12);
    chk_rd(1, 8'hFF, "R2 restart mask");
    wr_port(1, 8'h40); wr_port(1, 8'h7F);
    chk_rd(1, 8'h7F, "R3 skip cascade and mode");
    set_irq(8'h80); chk_irq(1, "R7 top line");
    do_ack(8'h47);
    chk_irq(0, "R8 serviced");
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R8 queue drained", expq.size(), 0);
    report();
  end
endmodule